// File: doc/BRIEF.md
# Programmable Input Toggle Generator

This block synthesises a square wave on selected bits of a shared input port byte. Software presents a high duration, a low duration, a repeat count and a bit mask, then pulses a start command. The generator counts down the interval for the present level of the generated bit. On every expiry it inverts the selected bits and merges them into the port value without touching any other bit. It then reloads the interval for the new level, until the repeat budget is spent. A clear command stops it at any time and leaves the level where it is.

Durations are counted in bus cycles of four input clocks each. A duration of zero is treated as one bus cycle. A status view exposes whether the generator is running, the present generated level and the number of bus cycles left in the current interval.

The control is a three-state machine. IDLE is the state after reset, when the generator has never run. RUN means an interval is counting. DONE means it was stopped by a clear or ran out of transitions. The transitions are:
- START: IDLE→RUN or DONE→RUN on a start pulse without clear.
- RESTART: RUN→RUN on a start pulse while running.
- RELOAD: RUN→RUN on an expiry with repeat budget left.
- LAST: RUN→DONE on an expiry with the budget at zero.
- HALT: RUN→DONE on a clear.
- Reset returns every state to IDLE.

Top module: `port_toggle_gen`

## Requirements
- R1: While reset is asserted, and after it is released, running is 0, level is 0, remaining is 0, and `port_out_o` equals `port_in_i`.
- R2: `port_out_o` carries `port_in_i` on every bit outside the mask captured at the last start. Every bit inside that mask reads 1 when the generated level is 1 and 0 when it is 0.
- R3: After a transition, the next interval uses the high duration if the level is now 1 and the low duration if it is now 0.
- R4: While running, `remaining_o` reports the bus cycles left in the current interval, which is never zero, and it falls by at most one per clock. When not running it reads 0.
- R5: A bus cycle is four clocks. The first transition after a start occurs exactly 4·D clock edges after the start edge, where D is the duration for the level at start.
- R6: A duration of zero is treated as one bus cycle.
- R7: A repeat count of N yields exactly N+1 transitions. Running drops on the same clock edge as the last transition.
- R8: A start while running cancels the pending interval and begins a new one from the present level, using the configuration presented with the new start.
- R9: A clear stops the generator on the next edge, holds the level and zeroes remaining. A clear presented together with a start wins, and the generator does not run.
- R10: The duration, repeat and mask inputs are sampled only on a start edge. Changing them while running has no effect on the wave.
- R11: Asserting reset while running stops the generator and forces the level to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_high_i | input | DUR_W | Bus cycles spent at level 1 |
| cfg_low_i | input | DUR_W | Bus cycles spent at level 0 |
| cfg_repeat_i | input | REP_W | Transitions allowed after the first |
| cfg_mask_i | input | PORT_W | Port bits driven by the generator |
| cmd_start_i | input | 1 | Start or restart pulse |
| cmd_clear_i | input | 1 | Stop pulse, wins over start |
| port_in_i | input | PORT_W | Port value from other sources |
| port_out_o | output | PORT_W | Port value with generated bits merged |
| active_o | output | 1 | Generator is counting an interval |
| level_o | output | 1 | Present generated level |
| remaining_o | output | DUR_W | Bus cycles left in the current interval |

## Verification
The bench builds the block with an 8-bit port, 16-bit durations and an 8-bit repeat count, and keeps the four-clock bus cycle. The narrow repeat width makes the full-scale budget of 255 reachable, so one run checks the 256-transition wrap back to the starting level in about a thousand clocks. The short durations keep each interval, restart and clear race to a few tens of clocks, which leaves room for the zero-duration clamp, a mid-run reset and a start that collides with an expiry.

// File: rtl/tg_pkg.sv
package tg_pkg;

    typedef enum logic [1:0] {
        TG_IDLE = 2'd0,
        TG_RUN  = 2'd1,
        TG_DONE = 2'd2
    } tg_state_e;

endpackage

// File: rtl/tg_prescaler.sv
module tg_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + PW'(1);
            end
        end
    end

    assign tick_o = en_i && (cnt_q == LAST);

endmodule

// File: rtl/tg_interval.sv
module tg_interval #(
    parameter int DUR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [DUR_W-1:0] load_val_i,
    output logic [DUR_W-1:0] remaining_o,
    output logic             expire_o
);
    localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

    logic [DUR_W-1:0] rem_q;
    logic [DUR_W-1:0] clamped;

    // a zero duration would never expire; it counts as one bus cycle
    assign clamped = (load_val_i == '0) ? ONE : load_val_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (clear_i) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= clamped;
        end else if (en_i && tick_i && (rem_q != '0)) begin
            rem_q <= rem_q - ONE;
        end
    end

    assign remaining_o = rem_q;
    assign expire_o    = en_i && tick_i && (rem_q == ONE);

endmodule

// File: rtl/tg_merge.sv
module tg_merge #(
    parameter int PORT_W = 8
) (
    input  logic [PORT_W-1:0] port_i,
    input  logic [PORT_W-1:0] mask_i,
    input  logic              level_i,
    output logic [PORT_W-1:0] port_o
);
    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        assign port_o[b] = mask_i[b] ? level_i : port_i[b];
    end

endmodule

// File: rtl/port_toggle_gen.sv
module port_toggle_gen #(
    parameter int PORT_W   = 8,
    parameter int DUR_W    = 32,
    parameter int REP_W    = 32,
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUR_W-1:0]  cfg_high_i,
    input  logic [DUR_W-1:0]  cfg_low_i,
    input  logic [REP_W-1:0]  cfg_repeat_i,
    input  logic [PORT_W-1:0] cfg_mask_i,
    input  logic              cmd_start_i,
    input  logic              cmd_clear_i,
    input  logic [PORT_W-1:0] port_in_i,
    output logic [PORT_W-1:0] port_out_o,
    output logic              active_o,
    output logic              level_o,
    output logic [DUR_W-1:0]  remaining_o
);
    import tg_pkg::*;

    localparam logic [REP_W-1:0] REP_ONE = REP_W'(1);

    tg_state_e state_q, state_d;

    logic [DUR_W-1:0]  high_q, low_q;
    logic [REP_W-1:0]  rep_q;
    logic [PORT_W-1:0] mask_q;
    logic              level_q;

    logic              running;
    logic              go_start;
    logic              tick;
    logic              expire;
    logic              ev_expire;
    logic              ev_reload;
    logic              ev_last;
    logic              iv_load;
    logic [DUR_W-1:0]  iv_val;
    logic [DUR_W-1:0]  iv_rem;

    assign running   = (state_q == TG_RUN);
    assign go_start  = cmd_start_i && !cmd_clear_i;
    // any command on the expiry edge cancels the pending transition
    assign ev_expire = expire && !cmd_start_i && !cmd_clear_i;
    assign ev_reload = ev_expire && (rep_q != '0);
    assign ev_last   = ev_expire && (rep_q == '0);

    // next interval: start takes the duration of the present level,
    // a reload takes the duration of the level about to be entered
    assign iv_load = go_start || ev_reload;
    always_comb begin
        if (go_start) begin
            iv_val = level_q ? cfg_high_i : cfg_low_i;
        end else begin
            iv_val = level_q ? low_q : high_q;
        end
    end

    tg_prescaler #(
        .PRESCALE (PRESCALE)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (running),
        .restart_i (go_start),
        .tick_o    (tick)
    );

    tg_interval #(
        .DUR_W (DUR_W)
    ) u_interval (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (running),
        .tick_i      (tick),
        .clear_i     (cmd_clear_i),
        .load_i      (iv_load),
        .load_val_i  (iv_val),
        .remaining_o (iv_rem),
        .expire_o    (expire)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TG_IDLE: begin
                if (go_start) state_d = TG_RUN;            // START
            end
            TG_RUN: begin
                if (cmd_clear_i)      state_d = TG_DONE;   // HALT
                else if (cmd_start_i) state_d = TG_RUN;    // RESTART
                else if (ev_last)     state_d = TG_DONE;   // LAST
                else                  state_d = TG_RUN;    // RELOAD or counting
            end
            TG_DONE: begin
                if (go_start) state_d = TG_RUN;            // START
            end
            default: state_d = TG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // configuration capture, repeat budget and generated level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_q  <= '0;
            low_q   <= '0;
            mask_q  <= '0;
            rep_q   <= '0;
            level_q <= 1'b0;
        end else begin
            if (go_start) begin
                high_q <= cfg_high_i;
                low_q  <= cfg_low_i;
                mask_q <= cfg_mask_i;
            end
            if (cmd_clear_i) begin
                rep_q <= '0;
            end else if (go_start) begin
                rep_q <= cfg_repeat_i;
            end else if (ev_reload) begin
                rep_q <= rep_q - REP_ONE;
            end
            if (ev_expire) begin
                level_q <= ~level_q;
            end
        end
    end

    tg_merge #(
        .PORT_W (PORT_W)
    ) u_merge (
        .port_i  (port_in_i),
        .mask_i  (mask_q),
        .level_i (level_q),
        .port_o  (port_out_o)
    );

    // outputs
    always_comb begin
        active_o    = running;
        level_o     = level_q;
        remaining_o = iv_rem;
    end

endmodule

// File: rtl/port_toggle_gen_chk.sv
module port_toggle_gen_chk #(
    parameter int DUR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start_i,
    input logic             cmd_clear_i,
    input logic             active_o,
    input logic             level_o,
    input logic [DUR_W-1:0] remaining_o
);
    p_idle_rem_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (remaining_o == '0));

    p_active_rem_nz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> (remaining_o != '0));

    p_rem_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !cmd_start_i && !cmd_clear_i && (remaining_o > DUR_W'(1)))
        |=> ((remaining_o == $past(remaining_o)) ||
             (remaining_o == $past(remaining_o) - DUR_W'(1))));

    p_level_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_o) |-> $past(active_o));

    p_clear_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clear_i |=> (!active_o && $stable(level_o)));

    p_start_arms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start_i && !cmd_clear_i) |=> (active_o && $stable(level_o)));

endmodule

bind port_toggle_gen port_toggle_gen_chk #(
    .DUR_W (DUR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start_i (cmd_start_i),
    .cmd_clear_i (cmd_clear_i),
    .active_o    (active_o),
    .level_o     (level_o),
    .remaining_o (remaining_o)
);

// File: tb/port_toggle_gen_tb_top.sv
`timescale 1ns/1ps
module port_toggle_gen_tb_top;

    localparam int PW = 8;
    localparam int DW = 16;
    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] cfg_high = '0;
    logic [DW-1:0] cfg_low = '0;
    logic [RW-1:0] cfg_repeat = '0;
    logic [PW-1:0] cfg_mask = '0;
    logic          cmd_start = 1'b0;
    logic          cmd_clear = 1'b0;
    logic [PW-1:0] port_in = '0;
    logic [PW-1:0] port_out;
    logic          active;
    logic          level;
    logic [DW-1:0] remaining;

    int checks = 0;
    int fails = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    port_toggle_gen #(
        .PORT_W   (PW),
        .DUR_W    (DW),
        .REP_W    (RW),
        .PRESCALE (4)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_high_i   (cfg_high),
        .cfg_low_i    (cfg_low),
        .cfg_repeat_i (cfg_repeat),
        .cfg_mask_i   (cfg_mask),
        .cmd_start_i  (cmd_start),
        .cmd_clear_i  (cmd_clear),
        .port_in_i    (port_in),
        .port_out_o   (port_out),
        .active_o     (active),
        .level_o      (level),
        .remaining_o  (remaining)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference: absolute event times ----------------
    longint edge_no = 0;
    bit     m_act = 0;
    bit     m_lvl = 0;
    logic [PW-1:0] m_mask = '0;
    longint m_next = 0;
    longint m_left = 0;
    longint m_hi = 0;
    longint m_lo = 0;

    function automatic longint bus_len(input longint d);
        return (d == 0) ? 1 : d;
    endfunction

    always @(posedge clk) begin
        edge_no++;
        if (!rst_n) begin
            m_act = 0; m_lvl = 0; m_mask = '0; m_left = 0;
        end else if (cmd_clear) begin
            m_act = 0;
        end else if (cmd_start) begin
            m_mask = cfg_mask; m_hi = cfg_high; m_lo = cfg_low;
            m_left = cfg_repeat; m_act = 1;
            m_next = edge_no + 4 * bus_len(m_lvl ? m_hi : m_lo);
        end else if (m_act && edge_no == m_next) begin
            m_lvl = !m_lvl;
            if (m_left > 0) begin
                m_left--;
                m_next = edge_no + 4 * bus_len(m_lvl ? m_hi : m_lo);
            end else begin
                m_act = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            longint e_rem;
            logic [PW-1:0] e_port;
            e_rem  = m_act ? (m_next - edge_no + 3) / 4 : 0;
            e_port = (port_in & ~m_mask) | (m_lvl ? m_mask : '0);
            chk(port_out == e_port, "R2 port merge", port_out, e_port);
            chk(level == m_lvl, "R3 level", level, m_lvl);
            chk(remaining == DW'(e_rem), "R4 remaining", remaining, e_rem);
            chk(active == m_act, "R7 active", active, m_act);
        end
    end

    // ---------------- stimulus ----------------
    task automatic start_gen(input int hi, input int lo, input int rep, input logic [PW-1:0] mk);
        cfg_high = DW'(hi); cfg_low = DW'(lo); cfg_repeat = RW'(rep); cfg_mask = mk;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic wait_level_change(output int n);
        logic l0;
        l0 = level;
        n = 1;
        while (level == l0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_to_stop(output int tr, output int clks);
        logic prev;
        prev = level;
        tr = 0;
        clks = 1;
        while (active && clks < 20000) begin
            @(negedge clk);
            clks++;
            if (level != prev) tr++;
            prev = level;
        end
    endtask

    initial begin
        int n, tr, c;
        port_in = 8'hA5;
        repeat (3) @(negedge clk);
        chk(port_out == 8'hA5 && !active && !level, "R1 in reset", port_out, 8'hA5);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);
        chk(port_out == port_in, "R1 after reset pass-through", port_out, port_in);
        chk(remaining == 0 && !active, "R1 after reset idle", remaining, 0);

        // basic wave: low 2, high 3, six transitions
        port_in = 8'h5A;
        start_gen(3, 2, 5, 8'h04);
        wait_level_change(n);
        chk(n == 4 * 2 + 1, "R5 first toggle after 4*low clocks", n, 9);
        chk(port_out == 8'h5E, "R2 masked bit set", port_out, 8'h5E);
        wait_level_change(n);
        chk(n - 1 == 4 * 3, "R3 high interval", n - 1, 12);
        port_in = 8'hF0;
        @(negedge clk);
        chk(port_out == 8'hF0, "R2 unmasked bits follow input", port_out, 8'hF0);
        count_to_stop(tr, c);
        chk(tr == 4, "R7 remaining transitions for repeat 5", tr, 4);
        chk(level == 1'b0, "R7 final level", level, 0);

        // zero durations clamp to one bus cycle
        start_gen(0, 0, 3, 8'h01);
        count_to_stop(tr, c);
        chk(c == 17, "R6 four one-cycle intervals", c, 17);
        chk(tr == 4, "R6 transition count", tr, 4);

        // configuration changes while running are ignored
        start_gen(1, 5, 0, 8'h02);
        cfg_low = 16'd1; cfg_high = 16'd1; cfg_mask = 8'hFF;
        wait_level_change(n);
        chk(n == 21, "R10 low time kept at start value", n, 21);
        chk(!active, "R7 repeat zero stops after one transition", active, 0);
        chk(port_out == (port_in | 8'h02), "R10 mask kept at start value", port_out, port_in | 8'h02);

        // restart mid-interval
        start_gen(10, 1, 2, 8'h02);
        chk(remaining == 10, "R4 remaining loaded with high time", remaining, 10);
        repeat (6) @(negedge clk);
        start_gen(2, 1, 2, 8'h02);
        wait_level_change(n);
        chk(n == 9, "R8 restart from current level", n, 9);

        // clear holds level
        cmd_clear = 1'b1;
        @(negedge clk);
        cmd_clear = 1'b0;
        chk(!active && remaining == 0, "R9 clear stops", remaining, 0);
        repeat (40) @(negedge clk);
        chk(level == 1'b0 && !active, "R9 level held after clear", level, 0);

        // clear and start together
        cfg_high = 16'd1; cfg_low = 16'd1; cfg_repeat = 8'd3;
        cmd_clear = 1'b1; cmd_start = 1'b1;
        @(negedge clk);
        cmd_clear = 1'b0; cmd_start = 1'b0;
        chk(!active, "R9 clear wins over start", active, 0);
        repeat (10) @(negedge clk);
        chk(level == 1'b0, "R9 no transition after collision", level, 0);

        // full-scale repeat budget
        start_gen(1, 1, 255, 8'h80);
        count_to_stop(tr, c);
        chk(tr == 256, "R7 repeat 255 gives 256 transitions", tr, 256);
        chk(c == 1025, "R5 total time of 256 one-cycle intervals", c, 1025);

        // reset while running
        start_gen(3, 1, 10, 8'h10);
        repeat (6) @(negedge clk);
        chk(level == 1'b1 && active, "R11 running before reset", level, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!active && !level && remaining == 0, "R11 reset cancels", active, 0);
        chk(port_out == port_in, "R11 reset pass-through", port_out, port_in);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(!active && level == 1'b0, "R11 stays stopped", active, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule